// File: doc/BRIEF.md
# Precision Time-of-Day Clock with Alarm

This block keeps absolute time for a network endpoint that has to agree on time with its peers. The time is held in three parts: whole seconds, nanoseconds, and a sub-nanosecond fraction. On every edge of its timer clock the block adds a programmable step, made of whole nanoseconds and a 16-bit fraction. When the nanosecond part reaches one billion, it wraps and carries into the seconds. Software can correct the step by a signed trim value, and can jump the clock to a new absolute time in a single cycle.

Two capture paths latch the running time into a snapshot register. One is a software command. The other is a hardware strobe of lower latency, which may be asynchronous to the timer clock. A snapshot is held, and flagged valid, until the reader acknowledges it. An alarm compares the running time against a programmed absolute seconds and nanoseconds value. When the time reaches or passes that value, it raises a sticky interrupt.

The register write port is a valid/ready port that lives in the timer clock domain. Bus adapters and any clock crossing for it sit outside this block.

Top module: `tod_clock`

## Requirements
- R1: While reset is asserted and right after it is released, the seconds, nanoseconds and fraction outputs are zero, `alarm_irq` and `cap_valid` are low, and the step is `RST_INC_NS` nanoseconds with a zero fraction.
- R2: On every timer clock edge with no load, the time advances by the step, where {nanoseconds, fraction} is treated as one fixed-point number.
- R3: When the nanoseconds would reach 1,000,000,000 or more, that amount is subtracted and the seconds increase by one. The carry propagates through the full seconds width, including across bit 32.
- R4: The step is written at address 2, with whole nanoseconds in bits [23:16] and the fraction in bits [15:0]. Fractional steps accumulate and carry into the nanoseconds.
- R5: Address 4 stages the nanoseconds, address 5 stages the fraction (bits [15:0]), address 6 stages the seconds bits [31:0], and address 7 stages the seconds bits [47:32] (from data [15:0]). A write to address 0 with bit 4 set loads all three fields at that edge, and counting resumes from them on the next edge.
- R6: With `TRIM_EN` set, the signed two's-complement value written at address 3, bits [15:0], is added to the step in units of the fraction.
- R7: Any write to address 8 (alarm nanoseconds), address 9 (alarm seconds [31:0]) or address 10 (alarm seconds [47:32]) arms the alarm. An armed and enabled alarm sets its flag on the edge after the time first reaches or passes the alarm value, and then disarms, so it fires once per arming.
- R8: The alarm flag stays set until a write to address 1 with bit 0 set clears it. `alarm_irq` is the flag gated by the enable, which is bit 0 of address 0.
- R9: If a time load jumps past an armed, enabled alarm value, the interrupt rises on the following edge.
- R10: A write to address 0 with bit 5 set captures the seconds and nanoseconds that were showing before that edge, and sets `cap_valid`.
- R11: A rising edge on `hw_cap_req` passes through a two-stage synchronizer and an edge detector. It captures the time that is showing just before the third timer edge after the request rises.
- R12: While `cap_valid` is high, the snapshot does not change and new capture requests are ignored. A `cap_ack` pulse clears `cap_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_tmr | input | 1 | Timer clock; one step per rising edge |
| rst_n | input | 1 | Active-low reset |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write accepted (always high) |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Register write data |
| hw_cap_req | input | 1 | Asynchronous hardware capture strobe |
| cap_ack | input | 1 | Snapshot read acknowledge |
| cap_valid | output | 1 | Snapshot holds an unread capture |
| cap_sec | output | 48 | Captured seconds |
| cap_ns | output | 32 | Captured nanoseconds |
| now_sec | output | 48 | Running seconds |
| now_ns | output | 32 | Running nanoseconds |
| now_frac | output | 16 | Running fraction of a nanosecond |
| alarm_irq | output | 1 | Alarm interrupt |

## Verification
The assertions assume that the host never stages or loads a nanosecond value of one billion or more. They also assume that the step plus the trim stays positive and below one second, so that at most one seconds carry can occur per edge. The stimulus keeps to these limits: every staged nanosecond value is below 999,999,999, the step is never more than 8.25 ns, and the trim is never larger than a quarter of a nanosecond. The hardware strobe is held high for several timer cycles, so the synchronizer always sees it.

// File: rtl/tod_pkg.sv
package tod_pkg;

   localparam int ADDR_W = 4;
   localparam longint unsigned NS_PER_SEC = 64'd1000000000;

   typedef enum logic [ADDR_W-1:0] {
      RA_CTRL      = 4'd0,
      RA_STATUS    = 4'd1,
      RA_RATE      = 4'd2,
      RA_TRIM      = 4'd3,
      RA_SET_NS    = 4'd4,
      RA_SET_FRAC  = 4'd5,
      RA_SET_SEC_L = 4'd6,
      RA_SET_SEC_H = 4'd7,
      RA_ALM_NS    = 4'd8,
      RA_ALM_SEC_L = 4'd9,
      RA_ALM_SEC_H = 4'd10
   } reg_addr_e;

   localparam int CTRL_EN_BIT   = 0;
   localparam int CTRL_LOAD_BIT = 4;
   localparam int CTRL_SNAP_BIT = 5;

endpackage

// File: rtl/tod_regs.sv
module tod_regs
   import tod_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int SEC_W      = 48,
   parameter int NS_W       = 32,
   parameter int FRAC_W     = 16,
   parameter int INC_NS_W   = 8,
   parameter int TRIM_W     = 16,
   parameter bit TRIM_EN    = 1'b1,
   parameter int RST_INC_NS = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_valid,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   output logic                       alarm_en,
   output logic [INC_NS_W-1:0]        inc_ns,
   output logic [FRAC_W-1:0]          inc_frac,
   output logic signed [TRIM_W-1:0]   trim,
   output logic [SEC_W-1:0]           set_sec,
   output logic [NS_W-1:0]            set_ns,
   output logic [FRAC_W-1:0]          set_frac,
   output logic                       load,
   output logic                       sw_cap,
   output logic [SEC_W-1:0]           alm_sec,
   output logic [NS_W-1:0]            alm_ns,
   output logic                       arm,
   output logic                       alarm_clr
);

   localparam int SEC_HI_W = SEC_W - DATA_W;

   logic is_ctrl;

   assign is_ctrl   = wr_valid && (wr_addr == RA_CTRL);
   assign load      = is_ctrl && wr_data[CTRL_LOAD_BIT];
   assign sw_cap    = is_ctrl && wr_data[CTRL_SNAP_BIT];
   assign alarm_clr = wr_valid && (wr_addr == RA_STATUS) && wr_data[0];
   assign arm       = wr_valid && ((wr_addr == RA_ALM_NS) ||
                                   (wr_addr == RA_ALM_SEC_L) ||
                                   (wr_addr == RA_ALM_SEC_H));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alarm_en <= 1'b0;
         inc_ns   <= INC_NS_W'(RST_INC_NS);
         inc_frac <= '0;
         set_sec  <= '0;
         set_ns   <= '0;
         set_frac <= '0;
         alm_sec  <= '0;
         alm_ns   <= '0;
      end else if (wr_valid) begin
         case (wr_addr)
            RA_CTRL:      alarm_en <= wr_data[CTRL_EN_BIT];
            RA_RATE: begin
               inc_frac <= wr_data[FRAC_W-1:0];
               inc_ns   <= wr_data[FRAC_W +: INC_NS_W];
            end
            RA_SET_NS:    set_ns   <= wr_data[NS_W-1:0];
            RA_SET_FRAC:  set_frac <= wr_data[FRAC_W-1:0];
            RA_SET_SEC_L: set_sec[DATA_W-1:0]     <= wr_data;
            RA_SET_SEC_H: set_sec[SEC_W-1:DATA_W] <= wr_data[SEC_HI_W-1:0];
            RA_ALM_NS:    alm_ns   <= wr_data[NS_W-1:0];
            RA_ALM_SEC_L: alm_sec[DATA_W-1:0]     <= wr_data;
            RA_ALM_SEC_H: alm_sec[SEC_W-1:DATA_W] <= wr_data[SEC_HI_W-1:0];
            default: ;
         endcase
      end
   end

   generate
      if (TRIM_EN) begin : g_trim_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               trim <= '0;
            else if (wr_valid && (wr_addr == RA_TRIM))
               trim <= wr_data[TRIM_W-1:0];
         end
      end else begin : g_no_trim
         assign trim = '0;
      end
   endgenerate

endmodule

// File: rtl/tod_counter.sv
module tod_counter
   import tod_pkg::*;
#(
   parameter int SEC_W    = 48,
   parameter int NS_W     = 32,
   parameter int FRAC_W   = 16,
   parameter int INC_NS_W = 8,
   parameter int TRIM_W   = 16,
   parameter bit TRIM_EN  = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [INC_NS_W-1:0]       inc_ns,
   input  logic [FRAC_W-1:0]         inc_frac,
   input  logic signed [TRIM_W-1:0]  trim,
   input  logic                      load,
   input  logic [SEC_W-1:0]          load_sec,
   input  logic [NS_W-1:0]           load_ns,
   input  logic [FRAC_W-1:0]         load_frac,
   output logic [SEC_W-1:0]          sec_o,
   output logic [NS_W-1:0]           ns_o,
   output logic [FRAC_W-1:0]         frac_o
);

   localparam int ACC_W = NS_W + FRAC_W;
   localparam logic [ACC_W:0] LIMIT = (ACC_W+1)'(NS_PER_SEC) << FRAC_W;

   logic [ACC_W-1:0] acc_q;
   logic [SEC_W-1:0] sec_q;
   logic [ACC_W:0]   step;
   logic [ACC_W:0]   sum;
   logic             wrap;

   generate
      if (TRIM_EN) begin : g_trimmed
         always_comb
            step = (ACC_W+1)'({inc_ns, inc_frac}) +
                   {{(ACC_W+1-TRIM_W){trim[TRIM_W-1]}}, trim};
      end else begin : g_fixed
         always_comb step = (ACC_W+1)'({inc_ns, inc_frac});
      end
   endgenerate

   assign sum  = {1'b0, acc_q} + step;
   assign wrap = (sum >= LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         sec_q <= '0;
      end else if (load) begin
         acc_q <= {load_ns, load_frac};
         sec_q <= load_sec;
      end else if (wrap) begin
         acc_q <= ACC_W'(sum - LIMIT);
         sec_q <= sec_q + 1'b1;
      end else begin
         acc_q <= sum[ACC_W-1:0];
      end
   end

   assign sec_o  = sec_q;
   assign ns_o   = acc_q[ACC_W-1:FRAC_W];
   assign frac_o = acc_q[FRAC_W-1:0];

   assert_ns_below_billion_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      ns_o < NS_W'(NS_PER_SEC));

   assert_sec_steps_by_one_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> (sec_o == $past(sec_o) || sec_o == $past(sec_o) + 1'b1));

   assert_load_takes_all_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (sec_o == $past(load_sec) && ns_o == $past(load_ns) &&
                frac_o == $past(load_frac)));

endmodule

// File: rtl/tod_alarm.sv
module tod_alarm #(
   parameter int SEC_W = 48,
   parameter int NS_W  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEC_W-1:0] now_sec,
   input  logic [NS_W-1:0]  now_ns,
   input  logic [SEC_W-1:0] alm_sec,
   input  logic [NS_W-1:0]  alm_ns,
   input  logic             enable,
   input  logic             arm,
   input  logic             clear,
   output logic             irq
);

   logic reached;
   logic fire;
   logic armed_q;
   logic flag_q;

   assign reached = (now_sec > alm_sec) ||
                    ((now_sec == alm_sec) && (now_ns >= alm_ns));
   assign fire    = armed_q && enable && reached;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         flag_q  <= 1'b0;
      end else begin
         if (arm)
            armed_q <= 1'b1;
         else if (fire)
            armed_q <= 1'b0;

         if (fire)
            flag_q <= 1'b1;
         else if (clear)
            flag_q <= 1'b0;
      end
   end

   assign irq = flag_q && enable;

   assert_irq_needs_enable_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> enable);

   assert_flag_rise_armed_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(armed_q) && $past(enable));

   assert_flag_sticky_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clear) |=> flag_q);

endmodule

// File: rtl/tod_capture.sv
module tod_capture #(
   parameter int SEC_W       = 48,
   parameter int NS_W        = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hw_req,
   input  logic             sw_req,
   input  logic             ack,
   input  logic [SEC_W-1:0] now_sec,
   input  logic [NS_W-1:0]  now_ns,
   output logic             cap_valid,
   output logic [SEC_W-1:0] cap_sec,
   output logic [NS_W-1:0]  cap_ns
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   hw_edge;
   logic                   take;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], hw_req};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign hw_edge = sync_q[SYNC_STAGES-1] && !prev_q;
   assign take    = (sw_req || hw_edge) && !cap_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_valid <= 1'b0;
         cap_sec   <= '0;
         cap_ns    <= '0;
      end else if (take) begin
         cap_valid <= 1'b1;
         cap_sec   <= now_sec;
         cap_ns    <= now_ns;
      end else if (ack) begin
         cap_valid <= 1'b0;
      end
   end

   assert_snapshot_held_R12 : assert property (@(posedge clk) disable iff (!rst_n)
      (cap_valid && !ack) |=> (cap_valid && $stable(cap_sec) && $stable(cap_ns)));

   assert_ack_clears_R12 : assert property (@(posedge clk) disable iff (!rst_n)
      (cap_valid && ack) |=> !cap_valid);

endmodule

// File: rtl/tod_clock.sv
module tod_clock
   import tod_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int SEC_W       = 48,
   parameter int NS_W        = 32,
   parameter int FRAC_W      = 16,
   parameter int INC_NS_W    = 8,
   parameter int TRIM_W      = 16,
   parameter bit TRIM_EN     = 1'b1,
   parameter int RST_INC_NS  = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk_tmr,
   input  logic                 rst_n,
   input  logic                 wr_valid,
   output logic                 wr_ready,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic                 hw_cap_req,
   input  logic                 cap_ack,
   output logic                 cap_valid,
   output logic [SEC_W-1:0]     cap_sec,
   output logic [NS_W-1:0]      cap_ns,
   output logic [SEC_W-1:0]     now_sec,
   output logic [NS_W-1:0]      now_ns,
   output logic [FRAC_W-1:0]    now_frac,
   output logic                 alarm_irq
);

   generate
      if (SEC_W <= DATA_W || SEC_W > 2 * DATA_W) begin : g_bad_sec
         $error("SEC_W must lie between DATA_W+1 and 2*DATA_W");
      end
      if (NS_W < 30 || NS_W > DATA_W) begin : g_bad_ns
         $error("NS_W must hold one billion and fit a data word");
      end
      if (INC_NS_W + FRAC_W > DATA_W) begin : g_bad_inc
         $error("step does not fit a data word");
      end
      if (TRIM_W > FRAC_W + INC_NS_W || TRIM_W > DATA_W) begin : g_bad_trim
         $error("TRIM_W too wide");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic                       alarm_en;
   logic [INC_NS_W-1:0]        inc_ns;
   logic [FRAC_W-1:0]          inc_frac;
   logic signed [TRIM_W-1:0]   trim;
   logic [SEC_W-1:0]           set_sec;
   logic [NS_W-1:0]            set_ns;
   logic [FRAC_W-1:0]          set_frac;
   logic                       load;
   logic                       sw_cap;
   logic [SEC_W-1:0]           alm_sec;
   logic [NS_W-1:0]            alm_ns;
   logic                       arm;
   logic                       alarm_clr;

   assign wr_ready = 1'b1;

   tod_regs #(
      .DATA_W(DATA_W), .SEC_W(SEC_W), .NS_W(NS_W), .FRAC_W(FRAC_W),
      .INC_NS_W(INC_NS_W), .TRIM_W(TRIM_W), .TRIM_EN(TRIM_EN),
      .RST_INC_NS(RST_INC_NS)
   ) u_regs (
      .clk(clk_tmr), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_data(wr_data), .alarm_en(alarm_en), .inc_ns(inc_ns),
      .inc_frac(inc_frac), .trim(trim), .set_sec(set_sec), .set_ns(set_ns),
      .set_frac(set_frac), .load(load), .sw_cap(sw_cap), .alm_sec(alm_sec),
      .alm_ns(alm_ns), .arm(arm), .alarm_clr(alarm_clr)
   );

   tod_counter #(
      .SEC_W(SEC_W), .NS_W(NS_W), .FRAC_W(FRAC_W), .INC_NS_W(INC_NS_W),
      .TRIM_W(TRIM_W), .TRIM_EN(TRIM_EN)
   ) u_counter (
      .clk(clk_tmr), .rst_n(rst_n), .inc_ns(inc_ns), .inc_frac(inc_frac),
      .trim(trim), .load(load), .load_sec(set_sec), .load_ns(set_ns),
      .load_frac(set_frac), .sec_o(now_sec), .ns_o(now_ns), .frac_o(now_frac)
   );

   tod_alarm #(
      .SEC_W(SEC_W), .NS_W(NS_W)
   ) u_alarm (
      .clk(clk_tmr), .rst_n(rst_n), .now_sec(now_sec), .now_ns(now_ns),
      .alm_sec(alm_sec), .alm_ns(alm_ns), .enable(alarm_en), .arm(arm),
      .clear(alarm_clr), .irq(alarm_irq)
   );

   tod_capture #(
      .SEC_W(SEC_W), .NS_W(NS_W), .SYNC_STAGES(SYNC_STAGES)
   ) u_capture (
      .clk(clk_tmr), .rst_n(rst_n), .hw_req(hw_cap_req), .sw_req(sw_cap),
      .ack(cap_ack), .now_sec(now_sec), .now_ns(now_ns),
      .cap_valid(cap_valid), .cap_sec(cap_sec), .cap_ns(cap_ns)
   );

   assert_reset_quiet_R1 : assert property (@(posedge clk_tmr) disable iff (!rst_n)
      $rose(rst_n) |-> (!alarm_irq && !cap_valid));

endmodule

// File: tb/test_tod_clock.sv
module test_tod_clock;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_valid = 1'b0;
   logic        wr_ready;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        hw_cap_req = 1'b0;
   logic        cap_ack = 1'b0;
   logic        cap_valid;
   logic [47:0] cap_sec;
   logic [31:0] cap_ns;
   logic [47:0] now_sec;
   logic [31:0] now_ns;
   logic [15:0] now_frac;
   logic        alarm_irq;

   int checks = 0;
   int errors = 0;
   logic en_bit = 1'b0;

   always #4 clk = ~clk;

   tod_clock i_tod_clock (
      .clk_tmr(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
      .wr_addr(wr_addr), .wr_data(wr_data), .hw_cap_req(hw_cap_req),
      .cap_ack(cap_ack), .cap_valid(cap_valid), .cap_sec(cap_sec),
      .cap_ns(cap_ns), .now_sec(now_sec), .now_ns(now_ns),
      .now_frac(now_frac), .alarm_irq(alarm_irq)
   );

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic set_time(input logic [47:0] s, input logic [31:0] n,
                           input logic [15:0] f);
      wr(4'd6, s[31:0]);
      wr(4'd7, {16'h0, s[47:32]});
      wr(4'd4, n);
      wr(4'd5, {16'h0, f});
      wr(4'd0, {26'h0, 1'b0, 1'b1, 3'b0, en_bit});
      check("R5", "loaded sec", 64'(now_sec), 64'(s));
      check("R5", "loaded ns", 64'(now_ns), 64'(n));
      check("R5", "loaded frac", 64'(now_frac), 64'(f));
   endtask

   task automatic t_reset;
      repeat (3) @(posedge clk);
      check("R1", "sec in reset", 64'(now_sec), 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      check("R1", "ns after reset", 64'(now_ns), 64'd0);
      check("R1", "frac after reset", 64'(now_frac), 64'd0);
      check("R1", "irq after reset", 64'(alarm_irq), 64'd0);
      check("R1", "cap_valid after reset", 64'(cap_valid), 64'd0);
   endtask

   task automatic t_rate;
      logic [31:0] n0;
      @(negedge clk);
      n0 = now_ns;
      repeat (10) @(posedge clk);
      @(negedge clk);
      check("R2", "default step of 8 ns x10", 64'(now_ns), 64'(n0 + 32'd80));
      check("R2", "no seconds change", 64'(now_sec), 64'd0);
   endtask

   task automatic t_rollover;
      set_time(48'd5, 32'd999_999_980, 16'd0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R3", "ns after wrap", 64'(now_ns), 64'd4);
      check("R3", "sec after wrap", 64'(now_sec), 64'd6);
      set_time(48'h0000_FFFF_FFFF, 32'd999_999_992, 16'd0);
      @(posedge clk);
      @(negedge clk);
      check("R3", "sec carry over bit 32", 64'(now_sec), 64'h1_0000_0000);
      check("R3", "ns zero after exact wrap", 64'(now_ns), 64'd0);
   endtask

   task automatic t_fraction;
      wr(4'd2, 32'h0001_8000);
      set_time(48'd7, 32'd100, 16'd0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R4", "ns with 1.5 ns step", 64'(now_ns), 64'd104);
      check("R4", "frac with 1.5 ns step", 64'(now_frac), 64'h8000);
      wr(4'd2, 32'h0008_0000);
   endtask

   task automatic t_trim;
      wr(4'd3, 32'h0000_4000);
      set_time(48'd7, 32'd0, 16'd0);
      repeat (4) @(posedge clk);
      @(negedge clk);
      check("R6", "positive trim ns", 64'(now_ns), 64'd33);
      check("R6", "positive trim frac", 64'(now_frac), 64'd0);
      wr(4'd3, 32'h0000_C000);
      set_time(48'd7, 32'd0, 16'd0);
      repeat (4) @(posedge clk);
      @(negedge clk);
      check("R6", "negative trim ns", 64'(now_ns), 64'd31);
      wr(4'd3, 32'h0);
   endtask

   task automatic t_alarm;
      int seen;
      en_bit = 1'b0;
      set_time(48'd10, 32'd0, 16'd0);
      wr(4'd9, 32'd10);
      wr(4'd10, 32'd0);
      wr(4'd8, 32'd800);
      en_bit = 1'b1;
      wr(4'd0, 32'h1);
      check("R7", "irq low before alarm time", 64'(alarm_irq), 64'd0);
      seen = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (alarm_irq) begin seen = 1; break; end
      end
      check("R7", "irq raised", 64'(seen), 64'd1);
      check("R7", "ns when irq first seen", 64'(now_ns), 64'd808);
      check("R7", "sec when irq first seen", 64'(now_sec), 64'd10);
      repeat (5) @(negedge clk);
      check("R8", "irq sticky", 64'(alarm_irq), 64'd1);
      en_bit = 1'b0;
      wr(4'd0, 32'h0);
      check("R8", "irq masked by enable", 64'(alarm_irq), 64'd0);
      en_bit = 1'b1;
      wr(4'd0, 32'h1);
      check("R8", "irq back after enable", 64'(alarm_irq), 64'd1);
      wr(4'd1, 32'h1);
      check("R8", "irq cleared by W1C", 64'(alarm_irq), 64'd0);
      repeat (5) @(negedge clk);
      check("R7", "no refire without rearm", 64'(alarm_irq), 64'd0);
   endtask

   task automatic t_step_past;
      wr(4'd9, 32'd100);
      wr(4'd10, 32'd0);
      wr(4'd8, 32'd0);
      check("R9", "irq low before step", 64'(alarm_irq), 64'd0);
      set_time(48'd200, 32'd0, 16'd0);
      check("R9", "irq low on load edge", 64'(alarm_irq), 64'd0);
      @(posedge clk);
      @(negedge clk);
      check("R9", "irq one edge after step", 64'(alarm_irq), 64'd1);
      wr(4'd1, 32'h1);
   endtask

   task automatic t_sw_capture;
      logic [47:0] s0;
      logic [31:0] n0;
      logic [31:0] n1;
      @(negedge clk);
      s0 = now_sec; n0 = now_ns;
      wr_valid = 1'b1; wr_addr = 4'd0; wr_data = {26'h0, 1'b1, 4'b0, en_bit};
      @(posedge clk);
      @(negedge clk);
      wr_valid = 1'b0;
      check("R10", "cap_valid after sw request", 64'(cap_valid), 64'd1);
      check("R10", "sw cap sec", 64'(cap_sec), 64'(s0));
      check("R10", "sw cap ns", 64'(cap_ns), 64'(n0));
      wr(4'd0, {26'h0, 1'b1, 4'b0, en_bit});
      n1 = cap_ns;
      check("R12", "second sw request ignored", 64'(n1), 64'(n0));
      @(negedge clk);
      cap_ack = 1'b1;
      @(posedge clk);
      @(negedge clk);
      cap_ack = 1'b0;
      check("R12", "ack clears valid", 64'(cap_valid), 64'd0);
   endtask

   task automatic t_hw_capture;
      logic [47:0] s0;
      logic [31:0] n0;
      @(negedge clk);
      hw_cap_req = 1'b1;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      check("R11", "no capture before third edge", 64'(cap_valid), 64'd0);
      s0 = now_sec; n0 = now_ns;
      @(posedge clk);
      @(negedge clk);
      check("R11", "cap_valid after hw strobe", 64'(cap_valid), 64'd1);
      check("R11", "hw cap sec", 64'(cap_sec), 64'(s0));
      check("R11", "hw cap ns", 64'(cap_ns), 64'(n0));
      repeat (3) @(negedge clk);
      hw_cap_req = 1'b0;
      repeat (4) @(negedge clk);
      hw_cap_req = 1'b1;
      repeat (6) @(negedge clk);
      hw_cap_req = 1'b0;
      check("R12", "hw request ignored while valid", 64'(cap_ns), 64'(n0));
      check("R12", "still valid before ack", 64'(cap_valid), 64'd1);
      cap_ack = 1'b1;
      @(posedge clk);
      @(negedge clk);
      cap_ack = 1'b0;
      check("R12", "ack clears hw snapshot", 64'(cap_valid), 64'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_rate();
      t_rollover();
      t_fraction();
      t_trim();
      t_alarm();
      t_step_past();
      t_sw_capture();
      t_hw_capture();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule